// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block tracks the pending state of a bank of shared interrupt sources and keeps a running answer to one question: which source should be signalled to the processor next? Each source has an incoming line that is either level-sensitive or edge-triggered. It also has an enable bit, an active bit, a one-bit group and an 8-bit priority. Two group enable bits switch whole groups on and off. The result is presented as an interrupt ID, its priority and its group, together with a single request line toward the processor interface.

The selector is a multi-cycle scanner driven by a two-state machine. In `ST_SCAN` it visits one source per clock in ascending ID order and keeps the best eligible candidate seen so far. The visit after the last source moves it to `ST_PUBLISH` (transition "sweep done"). In that state it copies the candidate to the output registers, clears the candidate, rewinds the index and returns to `ST_SCAN` (transition "restart"). A sweep takes N+1 cycles for N sources, so the outputs follow any input change within a fixed bound. Source k carries interrupt ID 32+k, and the bank ends at the configured line count.

Top module: `hpi_selector`

## Requirements
- R1: A source can be selected only when it is pending, its enable bit is 1, its active bit is 0 and its group is enabled. A source that is both active and pending is never selected.
- R2: Among the sources that may be selected, the one with the numerically smallest priority value wins.
- R3: When two eligible sources share the smallest priority, the one with the lower ID wins.
- R4: Source k (bit k of every per-source vector, priority at `src_prio[8k+7:8k]`) reports ID 32+k. Reported IDs lie in 32 to NUM_LINES-1, and NUM_LINES may be at most 1020.
- R5: When nothing is eligible, and from reset until the first result is published, the outputs are ID 1023, priority 0xFF, group 0 and `irq_req` low.
- R6: `irq_req` is high exactly when the reported priority is not 0xFF. A source whose priority is 0xFF is never reported.
- R7: For a source with `trig_edge`=1, a rising edge of its line or a `set_pend` pulse sets the pending bit, and the bit stays set while the line stays high. Only `clr_pend` clears it. A set or an edge in the same cycle as a clear leaves the bit set.
- R8: For a source with `trig_edge`=0, `pend_out` equals the line value of the previous cycle, and `set_pend` and `clr_pend` have no effect.
- R9: After any input change, the outputs show the result for the new inputs no later than 2*(N+1) rising clock edges later, where N = NUM_LINES-32.
- R10: `grp_en[0]` enables group 0 and `grp_en[1]` enables group 1 (`src_grp` bit = 0 or 1). `best_grp` reports the group of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | N | Incoming interrupt line per source |
| trig_edge | input | N | 1 = edge-triggered, 0 = level-sensitive |
| set_pend | input | N | Pulse that sets pending (edge sources only) |
| clr_pend | input | N | Pulse that clears pending (edge sources only) |
| src_en | input | N | Per-source enable |
| src_act | input | N | Per-source active flag |
| src_grp | input | N | Per-source group (0 or 1) |
| src_prio | input | 8*N | Per-source priority, 8 bits each |
| grp_en | input | 2 | Group enables, bit g for group g |
| pend_out | output | N | Current pending bits |
| best_id | output | 10 | Selected interrupt ID, 1023 if none |
| best_prio | output | 8 | Selected priority, 0xFF if none |
| best_grp | output | 1 | Group of the selected source |
| irq_req | output | 1 | Request to the processor interface |

## Verification
The bench goes after the tie at equal priority, including a tie between the first and the last source. A design that replaced the candidate on "less or equal" would report the higher ID there. It also covers a source that is active and pending, a disabled source and a disabled group, each with the best priority on offer. Reporting any of them shows that the eligibility terms are incomplete. Other cases are a priority of 0xFF, which must not raise the request, and the last ID in the bank, which exposes an off-by-one in the sweep length. On the line side, it holds an edge source's line high across a clear and fires set and clear together. It also pulses set and clear at a level source and samples the result exactly at the latency bound, which catches a scanner that is one cycle slower than documented.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
    localparam int ID_W        = 10;
    localparam int PRIO_W      = 8;
    localparam int SHARED_BASE = 32;
    localparam int MAX_LINES   = 1020;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

    typedef enum logic [0:0] {
        ST_SCAN    = 1'b0,
        ST_PUBLISH = 1'b1
    } scan_state_e;
endpackage

// File: rtl/hpi_pend_track.sv
module hpi_pend_track #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_line,
    input  logic [N_SRC-1:0] trig_edge,
    input  logic [N_SRC-1:0] set_pend,
    input  logic [N_SRC-1:0] clr_pend,
    output logic [N_SRC-1:0] pend
);
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        logic line_q;
        logic rise;
        assign rise = irq_line[k] & ~line_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q  <= 1'b0;
                pend[k] <= 1'b0;
            end else begin
                line_q <= irq_line[k];
                if (trig_edge[k]) begin
                    // a new event beats a clear in the same cycle
                    pend[k] <= (pend[k] & ~clr_pend[k]) | set_pend[k] | rise;
                end else begin
                    pend[k] <= irq_line[k];
                end
            end
        end
    end
endmodule

// File: rtl/hpi_elig.sv
module hpi_elig #(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] src_act,
    input  logic [N_SRC-1:0] src_grp,
    input  logic [1:0]       grp_en,
    output logic [N_SRC-1:0] elig
);
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        logic grp_ok;
        assign grp_ok  = src_grp[k] ? grp_en[1] : grp_en[0];
        assign elig[k] = pend[k] & src_en[k] & ~src_act[k] & grp_ok;
    end
endmodule

// File: rtl/hpi_scan.sv
module hpi_scan
    import hpi_pkg::*;
#(
    parameter int N_SRC    = 32,
    parameter int FIRST_ID = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        elig,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [N_SRC-1:0]        src_grp,
    output logic [ID_W-1:0]         best_id,
    output logic [PRIO_W-1:0]       best_prio,
    output logic                    best_grp,
    output logic                    irq_req
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SRC - 1);

    scan_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  run_idx_q;
    logic [PRIO_W-1:0] run_prio_q;
    logic              run_grp_q;
    logic              run_hit_q;
    logic [PRIO_W-1:0] cand_prio;
    logic              cand_win;

    assign cand_prio = src_prio[int'(idx_q)*PRIO_W +: PRIO_W];
    // strict compare: on equal priority the earlier (lower) ID stays
    assign cand_win  = elig[idx_q] && (cand_prio < run_prio_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:    if (idx_q == LAST_IDX) state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    // sweep registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            run_idx_q  <= '0;
            run_prio_q <= IDLE_PRIO;
            run_grp_q  <= 1'b0;
            run_hit_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SCAN: begin
                    if (cand_win) begin
                        run_idx_q  <= idx_q;
                        run_prio_q <= cand_prio;
                        run_grp_q  <= src_grp[idx_q];
                        run_hit_q  <= 1'b1;
                    end
                    if (idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
                end
                ST_PUBLISH: begin
                    idx_q      <= '0;
                    run_prio_q <= IDLE_PRIO;
                    run_grp_q  <= 1'b0;
                    run_hit_q  <= 1'b0;
                end
            endcase
        end
    end

    // output registers, loaded once per sweep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_id   <= SPURIOUS_ID;
            best_prio <= IDLE_PRIO;
            best_grp  <= 1'b0;
            irq_req   <= 1'b0;
        end else if (state_q == ST_PUBLISH) begin
            irq_req   <= run_hit_q;
            best_id   <= run_hit_q ? (ID_W'(FIRST_ID) + ID_W'(run_idx_q)) : SPURIOUS_ID;
            best_prio <= run_prio_q;
            best_grp  <= run_grp_q;
        end
    end
endmodule

// File: rtl/hpi_selector.sv
module hpi_selector
    import hpi_pkg::*;
#(
    parameter  int NUM_LINES = 64,
    localparam int N_SRC     = NUM_LINES - SHARED_BASE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        irq_line,
    input  logic [N_SRC-1:0]        trig_edge,
    input  logic [N_SRC-1:0]        set_pend,
    input  logic [N_SRC-1:0]        clr_pend,
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_SRC-1:0]        src_act,
    input  logic [N_SRC-1:0]        src_grp,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [1:0]              grp_en,
    output logic [N_SRC-1:0]        pend_out,
    output logic [ID_W-1:0]         best_id,
    output logic [PRIO_W-1:0]       best_prio,
    output logic                    best_grp,
    output logic                    irq_req
);
    if (NUM_LINES > MAX_LINES || NUM_LINES <= SHARED_BASE) begin : g_bad_cfg
        $error("hpi_selector: NUM_LINES out of range");
    end

    logic [N_SRC-1:0] elig;

    hpi_pend_track #(.N_SRC(N_SRC)) pend_i (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .trig_edge(trig_edge),
        .set_pend(set_pend), .clr_pend(clr_pend), .pend(pend_out)
    );

    hpi_elig #(.N_SRC(N_SRC)) elig_i (
        .pend(pend_out), .src_en(src_en), .src_act(src_act),
        .src_grp(src_grp), .grp_en(grp_en), .elig(elig)
    );

    hpi_scan #(.N_SRC(N_SRC), .FIRST_ID(SHARED_BASE)) scan_i (
        .clk(clk), .rst_n(rst_n), .elig(elig), .src_prio(src_prio),
        .src_grp(src_grp), .best_id(best_id), .best_prio(best_prio),
        .best_grp(best_grp), .irq_req(irq_req)
    );
endmodule

// File: rtl/hpi_selector_chk.sv
module hpi_selector_chk
    import hpi_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int N_SRC     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  irq_line,
    input logic [N_SRC-1:0]  trig_edge,
    input logic [N_SRC-1:0]  set_pend,
    input logic [N_SRC-1:0]  clr_pend,
    input logic [N_SRC-1:0]  pend_out,
    input logic [ID_W-1:0]   best_id,
    input logic [PRIO_W-1:0] best_prio,
    input logic              best_grp,
    input logic              irq_req
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (best_id == SPURIOUS_ID && best_prio == IDLE_PRIO && !best_grp)); // R5
    AST_REQ_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (best_prio != IDLE_PRIO)); // R6
    AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (best_id >= ID_W'(SHARED_BASE) && best_id < ID_W'(NUM_LINES))); // R4

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !$past(trig_edge[k])) |-> (pend_out[k] == $past(irq_line[k]))); // R8
        AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(trig_edge[k] && pend_out[k] && !clr_pend[k])) |-> pend_out[k]); // R7
        AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(trig_edge[k] && set_pend[k])) |-> pend_out[k]); // R7
    end
endmodule

bind hpi_selector hpi_selector_chk #(.NUM_LINES(NUM_LINES), .N_SRC(N_SRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .trig_edge(trig_edge),
    .set_pend(set_pend), .clr_pend(clr_pend), .pend_out(pend_out),
    .best_id(best_id), .best_prio(best_prio), .best_grp(best_grp), .irq_req(irq_req)
);

// File: tb/hpi_selector_tb.sv
module hpi_selector_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 32;
    localparam int LAT = 2 * (N + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq_line = '0, trig_edge = '0, set_pend = '0, clr_pend = '0;
    logic [N-1:0]   src_en = '1, src_act = '0, src_grp = '0;
    logic [N*8-1:0] src_prio = {N{8'h80}};
    logic [1:0]     grp_en = 2'b11;
    logic [N-1:0]   pend_out;
    logic [9:0]     best_id;
    logic [7:0]     best_prio;
    logic           best_grp;
    logic           irq_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpi_selector #(.NUM_LINES(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .trig_edge(trig_edge),
        .set_pend(set_pend), .clr_pend(clr_pend), .src_en(src_en), .src_act(src_act),
        .src_grp(src_grp), .src_prio(src_prio), .grp_en(grp_en), .pend_out(pend_out),
        .best_id(best_id), .best_prio(best_prio), .best_grp(best_grp), .irq_req(irq_req)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [31:0] lines;
        logic [31:0] en;
        logic [31:0] act;
        logic [31:0] grp;
        logic [1:0]  gen;
        logic [4:0]  ia;
        logic [7:0]  pa;
        logic [4:0]  ib;
        logic [7:0]  pb;
        logic [9:0]  eid;
        logic [7:0]  ep;
        logic        eg;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd5,  32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'b11, 5'd0,  8'h80, 5'd0,  8'h80, 10'd1023, 8'hFF, 1'b0}, // R5 nothing pending
        '{4'd1,  32'h0000_0020, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'b11, 5'd0,  8'h80, 5'd0,  8'h80, 10'd37,   8'h80, 1'b0}, // R1 single source
        '{4'd2,  32'h0000_0208, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'b11, 5'd9,  8'h10, 5'd3,  8'h40, 10'd41,   8'h10, 1'b0}, // R2 smaller value wins
        '{4'd3,  32'h0000_1080, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'b11, 5'd0,  8'h80, 5'd0,  8'h80, 10'd39,   8'h80, 1'b0}, // R3 tie, lower ID
        '{4'd1,  32'h0000_0014, 32'hFFFF_FFFB, 32'h0, 32'h0, 2'b11, 5'd2,  8'h01, 5'd0,  8'h80, 10'd36,   8'h80, 1'b0}, // R1 disabled skipped
        '{4'd1,  32'h0000_0014, 32'hFFFF_FFFF, 32'h4, 32'h0, 2'b11, 5'd2,  8'h01, 5'd0,  8'h80, 10'd36,   8'h80, 1'b0}, // R1 active+pending skipped
        '{4'd10, 32'h0000_0014, 32'hFFFF_FFFF, 32'h0, 32'h4, 2'b01, 5'd2,  8'h01, 5'd0,  8'h80, 10'd36,   8'h80, 1'b0}, // R10 group 1 off
        '{4'd10, 32'h0000_0014, 32'hFFFF_FFFF, 32'h0, 32'h4, 2'b10, 5'd2,  8'h01, 5'd0,  8'h80, 10'd34,   8'h01, 1'b1}, // R10 group 0 off
        '{4'd1,  32'h0000_0014, 32'hFFFF_FFFF, 32'h0, 32'h4, 2'b00, 5'd2,  8'h01, 5'd0,  8'h80, 10'd1023, 8'hFF, 1'b0}, // R1 both groups off
        '{4'd3,  32'h8000_0001, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'b11, 5'd0,  8'h00, 5'd31, 8'h00, 10'd32,   8'h00, 1'b0}, // R3 first vs last
        '{4'd4,  32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'b11, 5'd31, 8'h20, 5'd0,  8'h80, 10'd63,   8'h20, 1'b0}, // R4 last ID
        '{4'd6,  32'h0000_0040, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'b11, 5'd6,  8'hFF, 5'd0,  8'h80, 10'd1023, 8'hFF, 1'b0}  // R6 prio 0xFF
    };

    task automatic chk(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", rq, what, got, exp);
        end
    endtask

    task automatic chk_result(input string rq, input logic [9:0] id, input logic [7:0] pr, input logic gr);
        chk(rq, "best_id", 32'(best_id), 32'(id));
        chk(rq, "best_prio", 32'(best_prio), 32'(pr));
        chk(rq, "best_grp", 32'(best_grp), 32'(gr));
        chk(rq, "irq_req", 32'(irq_req), 32'(pr != 8'hFF));
    endtask

    task automatic wait_lat();
        repeat (LAT) @(posedge clk);
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R5: reset state before the first publish
        chk_result("R5", 10'd1023, 8'hFF, 1'b0);
        chk("R5", "pend_out after reset", pend_out, 32'h0);

        // table of level-sensitive scenarios
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            irq_line = VECS[v].lines;
            src_en   = VECS[v].en;
            src_act  = VECS[v].act;
            src_grp  = VECS[v].grp;
            grp_en   = VECS[v].gen;
            src_prio = {N{8'h80}};
            src_prio[VECS[v].ia*8 +: 8] = VECS[v].pa;
            src_prio[VECS[v].ib*8 +: 8] = VECS[v].pb;
            wait_lat();
            chk($sformatf("R%0d vec%0d", VECS[v].rq, v), "best_id", 32'(best_id), 32'(VECS[v].eid));
            chk($sformatf("R%0d vec%0d", VECS[v].rq, v), "best_prio", 32'(best_prio), 32'(VECS[v].ep));
            chk($sformatf("R%0d vec%0d", VECS[v].rq, v), "best_grp", 32'(best_grp), 32'(VECS[v].eg));
            chk($sformatf("R6 vec%0d", v), "irq_req", 32'(irq_req), 32'(VECS[v].ep != 8'hFF));
        end

        // back to a quiet state
        @(negedge clk);
        irq_line = '0; src_en = '1; src_act = '0; src_grp = '0; grp_en = 2'b11;
        src_prio = {N{8'h80}};
        trig_edge = (32'h1 << 10) | (32'h1 << 12);
        wait_lat();
        chk_result("R5", 10'd1023, 8'hFF, 1'b0);

        // R7: edge source 10 latches on a rising edge and holds while high
        @(negedge clk); irq_line[10] = 1'b1;
        step();
        chk("R7", "pend after edge", 32'(pend_out[10]), 32'h1);
        wait_lat();
        chk_result("R7", 10'd42, 8'h80, 1'b0);
        @(negedge clk); clr_pend[10] = 1'b1;
        step();
        chk("R7", "pend after clear", 32'(pend_out[10]), 32'h0);
        @(negedge clk); clr_pend[10] = 1'b0;
        step();
        chk("R7", "no re-trigger while line high", 32'(pend_out[10]), 32'h0);
        @(negedge clk); irq_line[10] = 1'b0;

        // R7: set and clear together leave the bit set
        @(negedge clk); set_pend[12] = 1'b1; clr_pend[12] = 1'b1;
        step();
        chk("R7", "set wins over clear", 32'(pend_out[12]), 32'h1);
        @(negedge clk); set_pend[12] = 1'b0;
        step();
        chk("R7", "clear alone", 32'(pend_out[12]), 32'h0);
        @(negedge clk); clr_pend[12] = 1'b0;

        // R8: level source 11 ignores set/clear and follows its line
        @(negedge clk); set_pend[11] = 1'b1;
        step();
        chk("R8", "set ignored on level source", 32'(pend_out[11]), 32'h0);
        @(negedge clk); set_pend[11] = 1'b0; irq_line[11] = 1'b1;
        step();
        chk("R8", "level high", 32'(pend_out[11]), 32'h1);
        @(negedge clk); clr_pend[11] = 1'b1;
        step();
        chk("R8", "clear ignored on level source", 32'(pend_out[11]), 32'h1);
        @(negedge clk); clr_pend[11] = 1'b0; irq_line[11] = 1'b0;
        step();
        chk("R8", "level low", 32'(pend_out[11]), 32'h0);
        wait_lat();
        chk_result("R8", 10'd1023, 8'hFF, 1'b0);

        // R9: a new request shows up exactly at the latency bound
        @(negedge clk);
        src_prio[20*8 +: 8] = 8'h30;
        irq_line[20] = 1'b1;
        repeat (LAT) @(posedge clk);
        #1;
        chk_result("R9", 10'd52, 8'h30, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule